// File: doc/BRIEF.md
# Clocked Controller for an Asynchronous Static RAM

This block sits between a synchronous host and an asynchronous 8K x 8 static RAM. The host offers one word at a time over a valid/ready handshake: an address, a write flag and, for writes, a data byte. The controller then drives the memory's address, two chip-select lines, write strobe, output-enable and data bus through a fixed sequence of phases. Each phase is held for a whole number of clock cycles, so the memory's minimum timings are met at any clock rate. For a read, the returned byte appears on the host side with a one-cycle valid pulse.

Every phase length is a parameter derived from the memory's nanosecond timings and the clock period. The conversion rounds up and never gives less than one cycle. Writes are strobe-controlled: the chip is selected first, then the write strobe goes low while the controller drives the bus, and the strobe rises before the chip is released. After a read, the controller leaves the bus undriven for a turnaround gap before it accepts more work.

The state machine has seven states:
- IDLE: ready, memory deselected. On an accepted read it goes to RD_ACCESS; on an accepted write it goes to WR_SETUP.
- RD_ACCESS: chip selected, output enable low. When its count expires it samples the bus and goes to RD_DONE.
- RD_DONE: one cycle with the response valid and the memory released. It goes to TURNAROUND.
- TURNAROUND: bus release gap. It goes to IDLE.
- WR_SETUP: chip selected, strobe still high. It goes to WR_PULSE.
- WR_PULSE: strobe low and data driven. It goes to WR_RECOVER.
- WR_RECOVER: strobe high, chip still selected. It goes to IDLE.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and in IDLE after it, the outputs are: mem_ce_n=1, mem_ce=0, mem_we_n=1, mem_oe_n=1, mem_dq_oe=0, req_ready=1 and rsp_valid=0.
- R2: A request is accepted only on a clock edge where req_valid and req_ready are both 1. req_ready is 1 only in IDLE. A request presented while the block is busy is ignored, so memory contents do not change.
- R3: For a read, the chip is selected (mem_ce_n=0, mem_ce=1) with mem_oe_n=0 and mem_we_n=1 for exactly ACC cycles, where ACC = ceil(70 ns / period). mem_dq_in is sampled at the end of the last of those cycles. rsp_valid is 1 for exactly one cycle, the (ACC+1)-th cycle after acceptance, and rsp_rdata carries the sampled byte.
- R4: After a read, the memory is deselected with mem_oe_n=1 for one RD_DONE cycle plus HZ = ceil(30 ns / period) TURNAROUND cycles. A read therefore occupies ACC+1+HZ cycles before req_ready returns.
- R5: A write first selects the chip with mem_we_n=1 and the driver off for SU = max(1, ceil(65 ns / period) - WP) cycles.
- R6: mem_we_n is 0 for exactly WP = max(ceil(50 ns / period), ceil(35 ns / period)) cycles. mem_dq_oe is 1 only while mem_we_n is 0. mem_addr and mem_dq_out do not change while mem_we_n is 0.
- R7: After mem_we_n rises, the chip stays selected for RC = max(1, ceil(70 ns / period) - SU - WP) cycles. A write occupies SU+WP+RC cycles before req_ready returns.
- R8: mem_oe_n stays 1 throughout a write.
- R9: A byte written to an address is returned by a later read of that address.
- R10: Every timing converts to cycles by ceiling division and is never less than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Byte to write |
| rsp_valid | output | 1 | Read byte valid, one-cycle pulse |
| rsp_rdata | output | DATA_W | Read byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip select, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Byte driven to memory |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DATA_W | Byte returned by memory |

## Verification
The bench models the memory so that it returns a garbage byte until address and selection have been stable for the full access time. A controller that samples one cycle early, or that drops the output enable too soon, therefore returns wrong data. The model commits a write only when the strobe rises, and it flags a strobe pulse of the wrong width, an address or data change while the strobe is low, and a strobe that rises after the chip is released. It also flags the controller driving the bus while the memory may still be driving it. Cycle counts from acceptance to response and to the next ready catch a mis-sized phase. A request held during a busy read, followed by a readback, catches a controller that accepts work outside IDLE.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER,
        ST_TURNAROUND
    } ctrl_state_t;

    // Round a nanosecond figure up to whole cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // a - b, but never less than one.
    function automatic int unsigned rem_min1(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 1;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture_rd,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [DATA_W-1:0] lat_wdata,
    output logic [DATA_W-1:0] rd_data
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_wdata <= '0;
        end else if (accept) begin
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture_rd) begin
            rd_data <= mem_dq_in;
        end
    end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int ACC_CYC   = 7,
    parameter int SETUP_CYC = 2,
    parameter int WP_CYC    = 5,
    parameter int REC_CYC   = 1,
    parameter int HZ_CYC    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             timer_zero,
    output logic             req_ready,
    output logic             accept,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             capture_rd,
    output logic             rsp_valid,
    output logic             mem_ce_n,
    output logic             mem_ce,
    output logic             mem_we_n,
    output logic             mem_oe_n,
    output logic             mem_dq_oe
);
    ctrl_state_t state, next;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next;
    end

    // Transitions
    always_comb begin
        next = state;
        unique case (state)
            ST_IDLE:       if (req_valid) next = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
            ST_RD_ACCESS:  if (timer_zero) next = ST_RD_DONE;
            ST_RD_DONE:    next = ST_TURNAROUND;
            ST_TURNAROUND: if (timer_zero) next = ST_IDLE;
            ST_WR_SETUP:   if (timer_zero) next = ST_WR_PULSE;
            ST_WR_PULSE:   if (timer_zero) next = ST_WR_RECOVER;
            ST_WR_RECOVER: if (timer_zero) next = ST_IDLE;
            default:       next = ST_IDLE;
        endcase
    end

    // Phase length loaded on entry to each timed state
    always_comb begin
        timer_load = (next != state);
        unique case (next)
            ST_RD_ACCESS:  timer_val = CNT_W'(ACC_CYC - 1);
            ST_TURNAROUND: timer_val = CNT_W'(HZ_CYC - 1);
            ST_WR_SETUP:   timer_val = CNT_W'(SETUP_CYC - 1);
            ST_WR_PULSE:   timer_val = CNT_W'(WP_CYC - 1);
            ST_WR_RECOVER: timer_val = CNT_W'(REC_CYC - 1);
            default:       timer_val = '0;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready  = 1'b0;
        capture_rd = 1'b0;
        rsp_valid  = 1'b0;
        mem_ce_n   = 1'b1;
        mem_ce     = 1'b0;
        mem_we_n   = 1'b1;
        mem_oe_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_RD_ACCESS: begin
                mem_ce_n   = 1'b0;
                mem_ce     = 1'b1;
                mem_oe_n   = 1'b0;
                capture_rd = timer_zero;
            end
            ST_RD_DONE:    rsp_valid = 1'b1;
            ST_TURNAROUND: ;
            ST_WR_SETUP, ST_WR_RECOVER: begin
                mem_ce_n = 1'b0;
                mem_ce   = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_ce    = 1'b1;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            default: ;
        endcase
    end

    assign accept = req_ready && req_valid;

    // A response always follows a cycle with output enable low.
    assert_rsp_after_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));
    // The response is a single-cycle pulse.
    assert_rsp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // The strobe rises while the chip is still selected.
    assert_we_rise_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_ce));
    // Output enable was already high before a write strobe falls.
    assert_oe_high_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_oe_n) && mem_oe_n));
    // Driver never turns on in the cycle right after output enable was low.
    assert_no_drive_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> $past(mem_oe_n));
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 13,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_CYCLE_NS    = 70,
    parameter int T_ACCESS_NS   = 70,
    parameter int T_WPULSE_NS   = 50,
    parameter int T_CE_WEND_NS  = 65,
    parameter int T_DSETUP_NS   = 35,
    parameter int T_RELEASE_NS  = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned RC_CYC    = ns_to_cyc(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int unsigned ACC_CYC   = max_u(ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS), RC_CYC);
    localparam int unsigned WP_CYC    = max_u(ns_to_cyc(T_WPULSE_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_DSETUP_NS, CLK_PERIOD_NS));
    localparam int unsigned SETUP_CYC = rem_min1(ns_to_cyc(T_CE_WEND_NS, CLK_PERIOD_NS), WP_CYC);
    localparam int unsigned REC_CYC   = rem_min1(RC_CYC, SETUP_CYC + WP_CYC);
    localparam int unsigned HZ_CYC    = ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_CYC   = max_u(max_u(ACC_CYC, WP_CYC),
                                              max_u(max_u(SETUP_CYC, REC_CYC), HZ_CYC));
    localparam int CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             accept, timer_load, timer_zero, capture_rd;
    logic [CNT_W-1:0] timer_val;

    sram_ctrl_fsm #(
        .CNT_W(CNT_W), .ACC_CYC(ACC_CYC), .SETUP_CYC(SETUP_CYC),
        .WP_CYC(WP_CYC), .REC_CYC(REC_CYC), .HZ_CYC(HZ_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .timer_zero(timer_zero), .req_ready(req_ready), .accept(accept),
        .timer_load(timer_load), .timer_val(timer_val), .capture_rd(capture_rd),
        .rsp_valid(rsp_valid), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
    );

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val), .zero(timer_zero)
    );

    sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .capture_rd(capture_rd), .mem_dq_in(mem_dq_in),
        .lat_addr(mem_addr), .lat_wdata(mem_dq_out), .rd_data(rsp_rdata)
    );

    // Checker counters for the strobe and output-enable low widths
    logic [CNT_W:0] wlow_cnt, oelow_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wlow_cnt  <= '0;
            oelow_cnt <= '0;
        end else begin
            wlow_cnt  <= !mem_we_n ? wlow_cnt + 1'b1 : '0;
            oelow_cnt <= !mem_oe_n ? oelow_cnt + 1'b1 : '0;
        end
    end

    assert_we_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (wlow_cnt >= (CNT_W+1)'(WP_CYC)));
    assert_access_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oelow_cnt >= (CNT_W+1)'(ACC_CYC)));
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));
    assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));
endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int PER = 10;
    localparam int DEPTH = 1 << AW;

    // Expected phase lengths, from the requirements
    localparam int E_RCY = (70 + PER - 1) / PER;
    localparam int E_ACC = ((70 + PER - 1) / PER > E_RCY) ? (70 + PER - 1) / PER : E_RCY;
    localparam int E_WP0 = (50 + PER - 1) / PER;
    localparam int E_DS  = (35 + PER - 1) / PER;
    localparam int E_WP  = (E_WP0 > E_DS) ? E_WP0 : E_DS;
    localparam int E_CEW = (65 + PER - 1) / PER;
    localparam int E_SU  = (E_CEW > E_WP) ? E_CEW - E_WP : 1;
    localparam int E_RC  = (E_RCY > E_SU + E_WP) ? E_RCY - E_SU - E_WP : 1;
    localparam int E_HZ  = (30 + PER - 1) / PER;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] rsp_rdata, mem_dq_out;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_in = 8'hEE;

    always #(PER/2) clk = ~clk;

    sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_NS(PER)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Memory model, evaluated between clock edges
    logic [DW-1:0] mem [DEPTH];
    int rd_cnt = 0, sel_cnt = 0, wlow = 0, hold = 0;
    logic [AW-1:0] last_addr = '0, w_addr = '0;
    logic [DW-1:0] w_data = '0;
    bit prev_rd = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit sel, rd;
            sel = !mem_ce_n && mem_ce;
            rd  = sel && !mem_oe_n && mem_we_n;
            if (rd) rd_cnt = (prev_rd && mem_addr == last_addr) ? rd_cnt + 1 : 1;
            else    rd_cnt = 0;
            prev_rd = rd;
            last_addr = mem_addr;
            mem_dq_in <= (rd && rd_cnt >= E_ACC) ? mem[mem_addr] : 8'hEE;
            // bus contention: memory may drive for E_HZ cycles after release
            if (mem_dq_oe && hold > 0) check(0, "R4 driver during release", hold, 0);
            if (rd) hold = E_HZ; else if (hold > 0) hold--;
            sel_cnt = sel ? sel_cnt + 1 : 0;
            if (mem_dq_oe && mem_we_n) check(0, "R6 driver with strobe high", 1, 0);
            if (!mem_we_n) begin
                if (wlow > 0) begin
                    check(mem_addr == w_addr, "R6 address moved", mem_addr, w_addr);
                    check(mem_dq_out == w_data, "R6 data moved", mem_dq_out, w_data);
                end
                check(mem_oe_n, "R8 output enable during write", mem_oe_n, 1);
                check(mem_dq_oe, "R6 driver off in pulse", mem_dq_oe, 1);
                wlow++;
                w_addr = mem_addr;
                w_data = mem_dq_out;
            end else if (wlow > 0) begin
                check(wlow == E_WP, "R6 strobe width", wlow, E_WP);
                check(sel, "R7 selected at strobe rise", sel, 1);
                check(sel_cnt == E_SU + E_WP + 1, "R5 setup before strobe", sel_cnt - 1 - wlow, E_SU);
                mem[w_addr] = w_data;
                wlow = 0;
            end
        end
    end

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int n;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        n = 1;
        while (!req_ready && n < 100) begin
            check(!rsp_valid, "R3 no response on write", rsp_valid, 0);
            @(negedge clk); n++;
        end
        check(n == E_SU + E_WP + E_RC + 1, "R7 R10 write length", n - 1, E_SU + E_WP + E_RC);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        int n, n_rsp, rsp_seen;
        logic [DW-1:0] got;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        n = 1; n_rsp = 0; rsp_seen = 0; got = '0;
        while (!req_ready && n < 100) begin
            if (rsp_valid) begin rsp_seen++; n_rsp = n; got = rsp_rdata; end
            @(negedge clk); n++;
        end
        check(rsp_seen == 1, "R3 one response pulse", rsp_seen, 1);
        check(n_rsp == E_ACC + 1, "R3 response cycle", n_rsp, E_ACC + 1);
        check(got == exp, "R9 read data", got, exp);
        check(n == E_ACC + 2 + E_HZ, "R4 R10 read length", n - 1, E_ACC + 1 + E_HZ);
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int k);
        return DW'((a * 37 + 5 + k * 101) & 8'hFF);
    endfunction

    initial begin
        #(PER * 150000);
        check(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state while in reset
        check(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 memory idle in reset",
              {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
        rst_n = 1;
        @(negedge clk);
        check(req_ready && !rsp_valid, "R1 ready after reset", {req_ready, rsp_valid}, 2'b10);
        check(mem_ce_n && !mem_ce && !mem_dq_oe, "R1 deselected after reset",
              {mem_ce_n, mem_ce, mem_dq_oe}, 3'b100);

        // Sweep 1: write every address, then read every address
        for (int a = 0; a < DEPTH; a++) do_write(AW'(a), pat(a, 0));
        for (int a = 0; a < DEPTH; a++) do_read(AW'(a), pat(a, 0));
        // Sweep 2: descending order, write then immediate readback
        for (int a = DEPTH - 1; a >= 0; a--) begin
            do_write(AW'(a), ~pat(a, 1));
            do_read(AW'(a), ~pat(a, 1));
        end
        // Extremes of the data range
        do_write('0, 8'h00);
        do_write('1, 8'hFF);
        do_read('0, 8'h00);
        do_read('1, 8'hFF);

        // R2: a write held on the handshake during a busy read is ignored
        do_write(AW'(5), 8'h5A);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = AW'(9);
        @(negedge clk);
        req_write = 1; req_addr = AW'(5); req_wdata = 8'hC3;
        for (int i = 0; i < E_ACC + E_HZ; i++) begin
            check(!req_ready, "R2 ready low while busy", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        check(mem_ce_n && mem_we_n, "R2 no access after drop", {mem_ce_n, mem_we_n}, 2'b11);
        do_read(AW'(5), 8'h5A);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule